// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines into a pending register and picks a winner by fixed priority: line 0 is the most urgent and line 7 the least. It raises one interrupt output toward a processor. The processor answers with two active-low acknowledge strobes, which are sampled on the system clock. The first strobe moves the winning request into service. The second strobe places an 8-bit vector on a tri-state data bus. The vector is a programmable 5-bit base in the upper bits and the 3-bit line number in the lower bits.

Software reaches the block through a small register port. Through it, software can read the pending, in-service, mask and configuration state. It can write the mask, the vector base and the automatic end-of-interrupt option. It can also issue end-of-interrupt commands, either non-specific or for a named line. While a request is in service, requests of the same or lower priority are held off. A more urgent request can still nest on top of it.

Top module: `vic_top`

## Requirements
- R1: The pending register copies the request lines, one per bit, one clock after they are sampled. Requests are level-detected, so a line that stays high shows as pending again once its acknowledge has cleared the bit. The pending register reads at address 0.
- R2: With no handshake in progress, `int_out` is high exactly when some unmasked pending line has a lower index than every set in-service bit. Among eligible lines, the lowest index wins.
- R3: The clock that samples the first falling edge of `ack_n` has three effects. It sets the in-service bit of the winner, clears the winner's pending bit, and drops `int_out`. The bus stays undriven (`vec_oe` low) during this first strobe. The in-service register reads at address 1.
- R4: While the second strobe is low, `vec_oe` is high and `dbus` carries the vector: base in bits 7:3 and line index in bits 2:0.
- R5: With automatic EOI enabled, the in-service bit of the acknowledged line clears at the clock that samples the end of the second strobe. Configuration is written and read at address 3: base in bits 7:3 and the automatic-EOI enable in bit 0.
- R6: With automatic EOI disabled, the in-service bit stays set after the handshake. A write to address 0 with bit 7 set and bit 6 clear clears the lowest-index set in-service bit.
- R7: A write to address 0 with bits 7 and 6 both set clears the in-service bit named by bits 2:0.
- R8: A set bit in the mask register keeps its line from raising `int_out`. The mask is written and read at address 2.
- R9: A set in-service bit blocks its own line and all higher-index lines. A lower-index request still raises `int_out` and can be acknowledged, so service nests.
- R10: If no request is eligible at the first strobe, the second strobe returns the vector for line 7 and no in-service bit is set.
- R11: From the first strobe until the second strobe ends, `int_out` stays low whatever the requests do.
- R12: After reset, every register reads zero, and `int_out` and `vec_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Level request lines, bit 0 most urgent |
| int_out | output | 1 | Interrupt request to the processor |
| ack_n | input | 1 | Active-low acknowledge strobe |
| dbus | inout | 8 | Tri-state vector bus |
| vec_oe | output | 1 | High while the block drives `dbus` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |

## Verification
The bench drops a request in the same clock as the first strobe. A design that latched pending bits as edges would then still report the line, or skip the spurious line-7 vector. It raises a more urgent request between the strobes. A design that re-evaluated too early would pulse `int_out` in the gap, and one that ignored in-service blocking would fail to nest afterwards. Non-specific and specific EOI commands are issued with two nested lines in service, which exposes a clear of the wrong bit. An automatic-EOI handshake with the line still high shows whether the in-service bit clears while the level request returns as pending.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_GAP    = 2'd2,
        PH_SECOND = 2'd3
    } ack_phase_e;

    typedef enum logic [1:0] {
        RA_PEND_CMD = 2'd0,
        RA_INSV     = 2'd1,
        RA_MASK     = 2'd2,
        RA_CFG      = 2'd3
    } reg_addr_e;

    localparam int DEF_NUM_IRQ = 8;
    localparam int DEF_VEC_W   = 8;

endpackage

// File: rtl/vic_pick.sv
module vic_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    logic [N-1:0] lower_any;
    logic [N-1:0] first;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            if (gi == 0) begin : g_lsb
                assign lower_any[gi] = 1'b0;
            end else begin : g_up
                assign lower_any[gi] = lower_any[gi-1] | req[gi-1];
            end
            assign first[gi] = req[gi] & ~lower_any[gi];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    assign valid = |req;

endmodule

// File: rtl/vic_ack_seq.sv
module vic_ack_seq
    import vic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_n,
    output ack_phase_e phase,
    output logic       start1,
    output logic       start2,
    output logic       end2
);
    logic ack_prev;
    logic fall, rise;
    ack_phase_e phase_d;

    assign fall   = ack_prev & ~ack_n;
    assign rise   = ~ack_prev & ack_n;
    assign start1 = (phase == PH_IDLE)   && fall;
    assign start2 = (phase == PH_GAP)    && fall;
    assign end2   = (phase == PH_SECOND) && rise;

    always_comb begin
        phase_d = phase;
        case (phase)
            PH_IDLE:   if (fall) phase_d = PH_FIRST;
            PH_FIRST:  if (rise) phase_d = PH_GAP;
            PH_GAP:    if (fall) phase_d = PH_SECOND;
            PH_SECOND: if (rise) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            ack_prev <= 1'b1;
        end else begin
            phase    <= phase_d;
            ack_prev <= ack_n;
        end
    end

    // The second strobe can only begin after the first has ended.
    assert_second_after_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND && $past(phase) != PH_SECOND) |-> $past(phase) == PH_GAP);

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = DEF_NUM_IRQ,
    parameter int VEC_W   = DEF_VEC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic               int_out,
    input  logic               ack_n,
    inout  wire  [VEC_W-1:0]   dbus,
    output logic               vec_oe,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [VEC_W-1:0]   wdata,
    output logic [VEC_W-1:0]   rdata
);
    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int BASE_W = VEC_W - IDX_W;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              aeoi;
    } cfg_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             spurious;
    } grant_t;

    function automatic logic [NUM_IRQ-1:0] line_bit(input logic [IDX_W-1:0] i);
        logic [NUM_IRQ-1:0] b;
        b    = '0;
        b[i] = 1'b1;
        return b;
    endfunction

    logic [NUM_IRQ-1:0] pend_q, isr_q, mask_q;
    cfg_t               cfg_q;
    grant_t             gnt_q;

    ack_phase_e phase;
    logic       start1, start2, end2;

    logic             req_v, isr_v, elig;
    logic [IDX_W-1:0] req_idx, isr_idx;

    logic [NUM_IRQ-1:0] grant_set, eoi_clr, aeoi_clr;
    logic               cmd_wr, mask_wr, cfg_wr;

    vic_ack_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .ack_n  (ack_n),
        .phase  (phase),
        .start1 (start1),
        .start2 (start2),
        .end2   (end2)
    );

    vic_pick #(.N(NUM_IRQ), .IW(IDX_W)) u_req_pick (
        .req   (pend_q & ~mask_q),
        .valid (req_v),
        .idx   (req_idx)
    );

    vic_pick #(.N(NUM_IRQ), .IW(IDX_W)) u_isr_pick (
        .req   (isr_q),
        .valid (isr_v),
        .idx   (isr_idx)
    );

    assign elig    = req_v && (!isr_v || (req_idx < isr_idx));
    assign int_out = (phase == PH_IDLE) && elig;
    assign vec_oe  = (phase == PH_SECOND);
    assign dbus    = vec_oe ? {cfg_q.base, gnt_q.idx} : {VEC_W{1'bz}};

    assign cmd_wr  = wr_en && (addr == RA_PEND_CMD);
    assign mask_wr = wr_en && (addr == RA_MASK);
    assign cfg_wr  = wr_en && (addr == RA_CFG);

    always_comb begin
        eoi_clr = '0;
        if (cmd_wr && wdata[VEC_W-1]) begin
            if (wdata[VEC_W-2]) eoi_clr = line_bit(wdata[IDX_W-1:0]);
            else if (isr_v)     eoi_clr = line_bit(isr_idx);
        end
    end

    assign aeoi_clr  = (end2 && cfg_q.aeoi && !gnt_q.spurious) ? line_bit(gnt_q.idx) : '0;
    assign grant_set = (start1 && elig) ? line_bit(req_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            isr_q  <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
            gnt_q  <= '0;
        end else begin
            pend_q <= irq_in & ~grant_set;
            isr_q  <= (isr_q & ~eoi_clr & ~aeoi_clr) | grant_set;
            if (mask_wr) mask_q <= wdata[NUM_IRQ-1:0];
            if (cfg_wr) begin
                cfg_q.base <= wdata[VEC_W-1:IDX_W];
                cfg_q.aeoi <= wdata[0];
            end
            if (start1) begin
                gnt_q.idx      <= elig ? req_idx : {IDX_W{1'b1}};
                gnt_q.spurious <= !elig;
            end
        end
    end

    always_comb begin
        case (addr)
            RA_PEND_CMD: rdata = VEC_W'(pend_q);
            RA_INSV:     rdata = VEC_W'(isr_q);
            RA_MASK:     rdata = VEC_W'(mask_q);
            default:     rdata = {cfg_q.base, {(IDX_W-1){1'b0}}, cfg_q.aeoi};
        endcase
    end

    assert_no_int_in_handshake_R11: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> !int_out);

    assert_oe_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_oe) |-> !$past(ack_n));

    assert_isr_set_on_first_R3: assert property (@(posedge clk) disable iff (rst)
        (|(isr_q & ~$past(isr_q))) |-> (phase == PH_FIRST && $past(phase) == PH_IDLE));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        int_out |-> |(pend_q & ~mask_q));

    assert_spurious_no_isr_R10: assert property (@(posedge clk) disable iff (rst)
        (start1 && !elig) |=> ((isr_q & ~$past(isr_q)) == '0));

    assert_aeoi_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (end2 && cfg_q.aeoi && !gnt_q.spurious) |=> !isr_q[$past(gnt_q.idx)]);

endmodule

// File: tb/vic_top_test.sv
module vic_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq = '0;
    logic       ack_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    wire  [7:0] dbus;
    logic       int_out, vec_oe;
    logic [7:0] rdata;

    always #10 clk = ~clk;

    vic_top uut (
        .clk(clk), .rst(rst), .irq_in(irq), .int_out(int_out), .ack_n(ack_n),
        .dbus(dbus), .vec_oe(vec_oe), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // behavioural reference state
    logic [7:0] m_pend, m_isr, m_mask;
    logic [4:0] m_base;
    bit         m_aeoi, m_spur, m_ackp;
    int         m_phase, m_idx;

    function automatic int winner();
        for (int i = 0; i < 8; i++) begin
            if (m_isr[i]) return -1;
            if (m_pend[i] && !m_mask[i]) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_isr = 0; m_mask = 0; m_base = 0; m_aeoi = 0;
            m_spur = 0; m_ackp = 1; m_phase = 0; m_idx = 0;
        end else begin
            automatic bit fall = m_ackp && !ack_n;
            automatic bit rise = !m_ackp && ack_n;
            automatic int w = winner();
            automatic logic [7:0] np = irq;
            automatic logic [7:0] ni = m_isr;
            if (wr_en && addr == 0 && wdata[7]) begin
                if (wdata[6]) ni[wdata[2:0]] = 1'b0;
                else begin
                    for (int i = 0; i < 8; i++) if (m_isr[i]) begin ni[i] = 1'b0; break; end
                end
            end
            if (m_phase == 3 && rise && m_aeoi && !m_spur) ni[m_idx] = 1'b0;
            if (m_phase == 0 && fall) begin
                if (w >= 0) begin ni[w] = 1'b1; np[w] = 1'b0; m_idx = w; m_spur = 0; end
                else begin m_idx = 7; m_spur = 1; end
            end
            if (wr_en && addr == 2) m_mask = wdata;
            if (wr_en && addr == 3) begin m_base = wdata[7:3]; m_aeoi = wdata[0]; end
            case (m_phase)
                0: if (fall) m_phase = 1;
                1: if (rise) m_phase = 2;
                2: if (fall) m_phase = 3;
                default: if (rise) m_phase = 0;
            endcase
            m_pend = np; m_isr = ni; m_ackp = ack_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2/R11 int_out vs model", int_out, (m_phase == 0 && winner() >= 0) ? 1 : 0);
            chk("R3/R4 vec_oe vs model", vec_oe, (m_phase == 3) ? 1 : 0);
            if (m_phase == 3) chk("R4 vector vs model", dbus, {m_base, 3'(m_idx)});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input int exp_v);
        addr = a; #2; chk(tag, rdata, exp_v);
    endtask

    task automatic handshake(input string tag, input int exp_vec);
        ack_n = 0; tick();
        chk({tag, " bus idle in first strobe"}, vec_oe, 0);
        ack_n = 1; tick();
        ack_n = 0; tick();
        chk({tag, " oe in second strobe"}, vec_oe, 1);
        chk({tag, " vector"}, dbus, exp_vec);
        ack_n = 1; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        // R12: reset state
        chk("R12 int_out", int_out, 0);
        chk("R12 vec_oe", vec_oe, 0);
        rd(0, "R12 pend", 0); rd(1, "R12 insv", 0); rd(2, "R12 mask", 0); rd(3, "R12 cfg", 0);

        wr(3, 8'h50);                       // base 0x0A, no auto EOI
        irq = 8'h28; tick();
        rd(0, "R1 pending level copy", 8'h28);
        chk("R2 int_out raised", int_out, 1);

        // first strobe, line 3 drops at the same time
        ack_n = 0; irq[3] = 0; tick();
        chk("R3 int_out dropped", int_out, 0);
        chk("R3 bus idle", vec_oe, 0);
        rd(1, "R3 insv set", 8'h08);
        rd(0, "R3 pending cleared", 8'h20);
        ack_n = 1; irq[1] = 1; tick();
        chk("R11 quiet in gap", int_out, 0);
        tick();
        chk("R11 quiet in gap later", int_out, 0);
        ack_n = 0; tick();
        chk("R4 oe", vec_oe, 1);
        chk("R4 vector line3", dbus, 8'h53);
        ack_n = 1; tick();
        chk("R9 nested request raises int", int_out, 1);
        rd(1, "R6 insv kept", 8'h08);

        irq[1] = 0;
        handshake("R9 nested", 8'h51);
        rd(1, "R9 two in service", 8'h0A);
        chk("R9 line5 blocked", int_out, 0);

        wr(0, 8'h80);
        rd(1, "R6 nonspecific EOI", 8'h08);
        chk("R9 still blocked by line3", int_out, 0);
        wr(0, 8'hC3);
        rd(1, "R7 specific EOI", 8'h00);
        chk("R7 line5 now raises", int_out, 1);

        wr(2, 8'h20);
        chk("R8 masked", int_out, 0);
        rd(2, "R8 mask readback", 8'h20);
        wr(2, 8'h00);
        chk("R8 unmasked", int_out, 1);

        wr(3, 8'h51);
        rd(3, "R5 cfg readback", 8'h51);
        handshake("R5 aeoi", 8'h55);
        rd(1, "R5 insv auto cleared", 8'h00);
        rd(0, "R1 level re-pending", 8'h20);
        chk("R1 level re-raises", int_out, 1);

        irq = 8'h90; tick();
        handshake("R2 priority 4 over 7", 8'h54);

        irq = 8'h00; tick(); tick();
        chk("R10 no request", int_out, 0);
        handshake("R10 spurious", 8'h57);
        rd(1, "R10 no insv", 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule